// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Queue

This block sits between a 32-bit program-read port and an instruction decoder. It fills a 64-byte circular byte store with whole aligned 4-byte words, issuing 24-bit byte addresses as it goes. At its head it presents a six-byte window, so that the decoder can see and take one instruction of any length from one to six bytes in a single cycle. Filling and draining happen in the same cycle. A fetch is requested only when four bytes of room are guaranteed after the consumption of the current cycle. This is how the queue applies backpressure toward memory.

A flush with a target address discards everything buffered and restarts fetching at the word holding the target. Bytes of that first word that lie below the target are dropped. For short loops, the decoder side can arm a replay. The body starts at the head and has a given length and iteration count. Each time the last body byte is consumed, the head jumps back to the body's first byte without refetching it. Meanwhile, fetching continues with the code that follows the body. After the final pass, execution simply carries on sequentially.

Top module: `fetch_queue`

## Requirements
- R1: Byte i of `head_bytes` (bits 8i+7..8i) holds the program byte at address `head_addr`+i for every byte the decoder may take. In a fetched word, the byte at the lowest address comes from bits 7..0 of `fetch_data`.
- R2: `head_ok` is 1 exactly when `dec_len` is in 1..6 and at least `dec_len` bytes are buffered. A cycle with `dec_valid` and `head_ok` consumes `dec_len` bytes, and `head_addr` advances by that amount on the next cycle.
- R3: A `dec_len` of 0 or 7 never raises `head_ok` and consumes nothing, so `head_addr` stays put.
- R4: `fetch_addr` is always a multiple of 4. It advances by 4 after each cycle with `fetch_req` and `fetch_gnt` both high, and holds otherwise.
- R5: `fetch_req` is 1 exactly when the span from the oldest byte that must be kept to the write point is at most 60 bytes after this cycle's consumption. Outside a loop, the oldest kept byte is the head. During a loop, it is the body start.
- R6: The buffered byte count never exceeds 64. With no consumption after a flush to an aligned target, exactly 16 fetches are accepted and then `fetch_req` drops.
- R7: `flush` wins over everything else in its cycle, and any grant or consumption in that cycle is ignored. On the next cycle the queue is empty, `head_addr` equals the target, and `fetch_addr` is the target with its two low bits cleared. From the first fetched word, only the bytes at or above the target are kept.
- R8: `loop_arm` with `loop_len` in 1..60 and `loop_iters` N of 1 or more marks a body that starts at the head after this cycle's consumption. After the body's last byte is consumed, `head_addr` returns to the body start, N-1 times in total. The body is never refetched, and fetch addresses remain strictly sequential.
- R9: After the final pass, the head continues at the byte following the body. An arm with `loop_iters` of 0 or `loop_len` of 0 is ignored.
- R10: After reset the queue is empty, `head_addr` is 0 and `fetch_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Request for the word at `fetch_addr` |
| fetch_addr | output | 24 | Aligned program byte address |
| fetch_gnt | input | 1 | Memory accepts the request; `fetch_data` is valid this cycle |
| fetch_data | input | 32 | Four program bytes, lowest address in bits 7..0 |
| dec_valid | input | 1 | Decoder takes an instruction this cycle |
| dec_len | input | 3 | Length of that instruction in bytes |
| head_ok | output | 1 | Enough bytes buffered for a legal `dec_len` |
| head_bytes | output | 48 | Six bytes starting at the head |
| head_addr | output | 24 | Program address of the head byte |
| flush | input | 1 | Discard contents and restart at `flush_addr` |
| flush_addr | input | 24 | Restart target byte address |
| loop_arm | input | 1 | Capture a loop body starting at the head |
| loop_len | input | 7 | Body length in bytes |
| loop_iters | input | 8 | Total number of passes over the body |

## Verification
The main traffic is swept over every flush offset within a word, three grant patterns (always, alternate cycles, every third cycle), and fixed lengths 1 to 6 plus a rotating mix. Offsets expose dropped or misplaced leading bytes. The grant patterns separate a wrong space rule from a correct one, because they vary how full the queue runs. Fixed lengths catch errors in partial windows and in pointer wrap. Further runs cover an idle fill to capacity, illegal lengths, ignored arms, and two replays: a short aligned body with three passes and a 60-byte unaligned body. The replays tell a true jump-back apart from refetching, and a correct exit apart from an extra or missing pass.

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int QBYTES = 64,
  parameter int AW     = 24,
  parameter int WIN    = 6,
  parameter int CW     = 8,
  localparam int PW    = $clog2(QBYTES) + 1,
  localparam int IW    = PW - 1,
  localparam int LW    = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  input  logic              fetch_gnt,
  input  logic [31:0]       fetch_data,
  input  logic              dec_valid,
  input  logic [LW-1:0]     dec_len,
  output logic              head_ok,
  output logic [8*WIN-1:0]  head_bytes,
  output logic [AW-1:0]     head_addr,
  input  logic              flush,
  input  logic [AW-1:0]     flush_addr,
  input  logic              loop_arm,
  input  logic [PW-1:0]     loop_len,
  input  logic [CW-1:0]     loop_iters
);

  logic [7:0]    mem [QBYTES];
  logic [PW-1:0] rd, wr, cnt, rd_adv, keep;
  logic [PW-1:0] lp_base, lp_size;
  logic [AW-1:0] fpc, hpc, lp_pc, hpc_adv;
  logic [CW-1:0] lp_left;
  logic [1:0]    skip;
  logic          len_ok, take, wr_en, lp_on, lp_hit;

  assign cnt       = wr - rd;
  assign len_ok    = (dec_len != '0) && (int'(dec_len) <= WIN);
  assign head_ok   = len_ok && (cnt >= PW'(dec_len));
  assign take      = dec_valid && head_ok && !flush;
  assign rd_adv    = rd + (take ? PW'(dec_len) : '0);
  assign hpc_adv   = hpc + (take ? AW'(dec_len) : '0);
  assign lp_on     = lp_left != '0;
  assign keep      = lp_on ? lp_base : rd_adv;
  assign fetch_req = (wr - keep) <= PW'(QBYTES - 4);
  assign wr_en     = fetch_req && fetch_gnt && !flush;
  assign lp_hit    = lp_on && take && (rd_adv == lp_base + lp_size);

  assign fetch_addr = fpc;
  assign head_addr  = hpc;

  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign head_bytes[8*i +: 8] = mem[rd[IW-1:0] + IW'(i)];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (2'(b) >= skip)
          mem[wr[IW-1:0] + IW'(b) - IW'(skip)] <= fetch_data[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd      <= '0;
      wr      <= '0;
      fpc     <= '0;
      hpc     <= '0;
      skip    <= '0;
      lp_left <= '0;
      lp_base <= '0;
      lp_size <= '0;
      lp_pc   <= '0;
    end else if (flush) begin
      rd      <= wr;
      fpc     <= {flush_addr[AW-1:2], 2'b00};
      skip    <= flush_addr[1:0];
      hpc     <= flush_addr;
      lp_left <= '0;
    end else begin
      if (wr_en) begin
        wr   <= wr + PW'(3'd4 - {1'b0, skip});
        fpc  <= fpc + AW'(4);
        skip <= '0;
      end
      rd  <= rd_adv;
      hpc <= hpc_adv;
      if (lp_hit) begin
        if (lp_left > CW'(1)) begin
          rd      <= lp_base;
          hpc     <= lp_pc;
          lp_left <= lp_left - CW'(1);
        end else begin
          lp_left <= '0;
        end
      end
      if (loop_arm && loop_iters != '0 && loop_len != '0) begin
        lp_base <= rd_adv;
        lp_size <= loop_len;
        lp_pc   <= hpc_adv;
        lp_left <= loop_iters;
      end
    end
  end

endmodule

// File: rtl/fetch_queue_chk.sv
module fetch_queue_chk #(
  parameter int QBYTES = 64,
  parameter int AW     = 24,
  localparam int PW    = $clog2(QBYTES) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [AW-1:0] flush_addr,
  input logic          fetch_req,
  input logic          fetch_gnt,
  input logic [AW-1:0] fetch_addr,
  input logic          dec_valid,
  input logic          head_ok,
  input logic [AW-1:0] head_addr,
  input logic [PW-1:0] cnt
);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PW'(QBYTES));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0) && (head_addr == $past(flush_addr)));

  // R7
  flush_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr == {$past(flush_addr[AW-1:2]), 2'b00});

  // R4
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_gnt && !flush) |=> fetch_addr == $past(fetch_addr) + AW'(4));

  // R4
  hold_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fetch_req && fetch_gnt) && !flush) |=> $stable(fetch_addr));

  // R3
  idle_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dec_valid && head_ok) && !flush) |=> $stable(head_addr));

endmodule

bind fetch_queue fetch_queue_chk #(.QBYTES(QBYTES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
  .fetch_req(fetch_req), .fetch_gnt(fetch_gnt), .fetch_addr(fetch_addr),
  .dec_valid(dec_valid), .head_ok(head_ok), .head_addr(head_addr), .cnt(cnt)
);

// File: tb/fetch_queue_tb_top.sv
module fetch_queue_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        fetch_req, fetch_gnt = 0;
  logic [23:0] fetch_addr;
  logic [31:0] fetch_data;
  logic        dec_valid = 0;
  logic [2:0]  dec_len = 3'd1;
  logic        head_ok;
  logic [47:0] head_bytes;
  logic [23:0] head_addr;
  logic        flush = 0;
  logic [23:0] flush_addr = '0;
  logic        loop_arm = 0;
  logic [6:0]  loop_len = '0;
  logic [7:0]  loop_iters = '0;

  int checks = 0, fails = 0;
  int occ = 0, skp = 0, rem = 0, blen = 0, grants = 0;
  logic [23:0] exp_pc = '0, exp_fa = '0, base_pc = '0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_queue dut_i (.*);

  function automatic logic [7:0] pb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb fetch_data = {pb(fetch_addr + 24'd3), pb(fetch_addr + 24'd2),
                            pb(fetch_addr + 24'd1), pb(fetch_addr)};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit g, input bit dv, input logic [2:0] L,
                      input bit arm = 0, input int alen = 0, input int aiter = 0);
    bit legal, expok;
    int tl, keep;
    logic [23:0] pc_adv;
    @(negedge clk);
    fetch_gnt = g; dec_valid = dv; dec_len = L; flush = 0;
    loop_arm = arm; loop_len = 7'(alen); loop_iters = 8'(aiter);
    #1;
    chk(head_addr == exp_pc, "R2", "head_addr", int'(head_addr), int'(exp_pc));
    legal = (L >= 3'd1) && (L <= 3'd6);
    expok = legal && (occ >= int'(L));
    chk(head_ok == expok, legal ? "R2" : "R3", "head_ok", int'(head_ok), int'(expok));
    if (head_ok && expok)
      for (int i = 0; i < int'(L); i++)
        chk(head_bytes[8*i +: 8] == pb(exp_pc + 24'(i)), "R1", "head byte",
            int'(head_bytes[8*i +: 8]), int'(pb(exp_pc + 24'(i))));
    tl = (dv && expok) ? int'(L) : 0;
    pc_adv = exp_pc + 24'(tl);
    keep = occ - tl + ((rem != 0) ? int'(pc_adv - base_pc) : 0);
    chk(fetch_req == (keep <= 60), "R5", "fetch_req", int'(fetch_req), int'(keep <= 60));
    if (fetch_req && g) begin
      chk(fetch_addr == exp_fa, (rem != 0) ? "R8" : "R4", "fetch_addr", int'(fetch_addr), int'(exp_fa));
      occ += 4 - skp; skp = 0; exp_fa += 24'd4; grants++;
    end
    occ -= tl;
    exp_pc = pc_adv;
    if (rem != 0 && tl != 0 && pc_adv == base_pc + 24'(blen)) begin
      if (rem > 1) begin exp_pc = base_pc; occ += blen; rem--; end
      else rem = 0;
    end
    if (arm && aiter != 0 && alen != 0) begin
      base_pc = pc_adv; blen = alen; rem = aiter;
    end
  endtask

  task automatic do_flush(input logic [23:0] t);
    @(negedge clk);
    flush = 1; flush_addr = t; fetch_gnt = 1; dec_valid = 1; dec_len = 3'd1; loop_arm = 0;
    occ = 0; exp_pc = t; exp_fa = {t[23:2], 2'b00}; skp = int'(t[1:0]); rem = 0; grants = 0;
  endtask

  task automatic run(input int n, input int gpat, input int lpat);
    bit g;
    for (int k = 0; k < n; k++) begin
      g = (gpat == 0) ? 1'b1 : (gpat == 1) ? k[0] : (k % 3 == 0);
      step(g, 1'b1, (lpat == 0) ? 3'((k % 6) + 1) : 3'(lpat));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] pc0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R10 reset state
    chk(head_addr == 24'd0, "R10", "head_addr", int'(head_addr), 0);
    chk(fetch_addr == 24'd0, "R10", "fetch_addr", int'(fetch_addr), 0);
    chk(head_ok == 1'b0, "R10", "head_ok", int'(head_ok), 0);
    step(1'b0, 1'b0, 3'd1);

    // sweep offsets, grant patterns, lengths
    for (int off = 0; off < 4; off++)
      for (int gp = 0; gp < 3; gp++)
        for (int lp = 0; lp < 7; lp++) begin
          do_flush(24'h001000 + 24'(gp * 256 + lp * 32 + off));
          step(1'b1, 1'b0, 3'd1);
          chk(head_addr == 24'h001000 + 24'(gp * 256 + lp * 32 + off), "R7", "flush head",
              int'(head_addr), int'(24'h001000 + 24'(gp * 256 + lp * 32 + off)));
          run(25, gp, lp);
        end

    // R6 fill to capacity
    do_flush(24'h005000);
    repeat (24) step(1'b1, 1'b0, 3'd6);
    chk(grants == 16, "R6", "grants to full", grants, 16);
    chk(fetch_req == 1'b0, "R6", "fetch_req full", int'(fetch_req), 0);
    run(8, 0, 6);

    // R3 illegal lengths
    pc0 = exp_pc;
    step(1'b1, 1'b1, 3'd0);
    step(1'b1, 1'b1, 3'd7);
    step(1'b0, 1'b0, 3'd1);
    chk(head_addr == pc0, "R3", "head after illegal len", int'(head_addr), int'(pc0));

    // R9 ignored arms
    do_flush(24'h006000);
    repeat (4) step(1'b1, 1'b0, 3'd2);
    step(1'b1, 1'b0, 3'd2, 1'b1, 8, 0);
    step(1'b1, 1'b0, 3'd2, 1'b1, 0, 3);
    run(6, 0, 2);
    step(1'b0, 1'b0, 3'd1);
    chk(head_addr == 24'h00600C, "R9", "head past ignored loop", int'(head_addr), 24'h00600C);

    // R8 short aligned body, three passes
    do_flush(24'h003000);
    repeat (3) step(1'b1, 1'b0, 3'd3);
    step(1'b1, 1'b0, 3'd3, 1'b1, 12, 3);
    run(15, 0, 3);
    step(1'b0, 1'b0, 3'd1);
    chk(head_addr == 24'h003015, "R8", "head after replay", int'(head_addr), 24'h003015);
    run(10, 1, 0);

    // R8 60-byte unaligned body, two passes
    do_flush(24'h004002);
    repeat (16) step(1'b1, 1'b0, 3'd5);
    step(1'b1, 1'b0, 3'd5, 1'b1, 60, 2);
    run(24, 0, 5);
    step(1'b0, 1'b0, 3'd1);
    chk(head_addr == 24'h00403E, "R9", "head after last pass", int'(head_addr), 24'h00403E);
    run(20, 2, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule